// File: doc/BRIEF.md
# Two-Way Write-Back Cache Tag Controller

This block holds the tag state of a two-way set-associative, write-back cache and runs the hit/miss sequence for one access at a time. An access brings the low virtual address bits, which select the set, and a physical tag, which is compared in both ways. Because the set index reaches one bit above the page offset, the set is chosen before address translation has finished. The data array and the lower-level memory bus sit outside the block. The block only tells them which way to use and when to write back or refill.

Each set keeps a tag, a valid bit and a dirty bit per way, plus one shared recency bit. With two ways, that one bit gives exact least-recently-used order. On a miss the block picks a victim. If the victim is dirty it first offers a writeback, then offers a fill request, then waits for a refill-complete pulse before it installs the new tag and answers.

Requests, responses, writebacks and fill requests all use valid/ready handshakes. A source holds valid and every field stable until ready is seen high at a clock edge. The block raises `req_ready` only when it is idle, so exactly one access is in flight. It keeps `rsp_valid`, `wb_valid` or `fill_valid` and their fields unchanged until the partner accepts. `fill_done` is a plain pulse and has no handshake.

Top module: `cache_tag_ctl`

## Requirements
- R1: After reset every way of every set is invalid, so the first access to any set misses, uses way 0 and produces no writeback.
- R2: An access hits when a valid way of its set holds a tag equal to `req_ptag`. `rsp_hit` is 1 and `rsp_way` names that way. Address bits 2:0 do not affect the outcome.
- R3: The set index is `req_vaddr[11:3]`. Two addresses that differ only in bit 11 select different sets.
- R4: On a miss where a way of the set is invalid, that way is filled. Way 0 is filled when both ways are invalid.
- R5: On a miss where both ways are valid, the victim is the least recently used way. Every hit and every install makes the other way the least recently used one.
- R6: A write hit marks its way dirty. Evicting a dirty way first raises `wb_valid` with the set index, the way and the old tag. `fill_valid` follows the cycle after the writeback is accepted.
- R7: An install after a read miss leaves the way clean. An install after a write miss leaves it dirty.
- R8: A hit produces neither a writeback nor a fill request. A miss whose victim is clean or invalid produces a fill request and no writeback.
- R9: `req_ready` is high only while idle. `rsp_valid`, `wb_valid` and `fill_valid`, with their fields, stay high and unchanged until the matching ready is seen.
- R10: At most one of `req_ready`, `rsp_valid`, `wb_valid` and `fill_valid` is high at a time. A `fill_done` pulse has no effect unless the block is waiting for a refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_vaddr | input | 12 | Low virtual address bits; 11:3 select the set, 2:0 the byte |
| req_ptag | input | 5 | Physical tag (frame number) |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Result taken |
| rsp_hit | output | 1 | 1 = hit, 0 = the access missed and was refilled |
| rsp_way | output | 1 | Way hit or installed |
| wb_valid | output | 1 | Dirty victim must be written back |
| wb_ready | input | 1 | Writeback accepted |
| wb_index | output | 9 | Set of the victim |
| wb_tag | output | 5 | Tag of the victim |
| wb_way | output | 1 | Way of the victim |
| fill_valid | output | 1 | Refill request |
| fill_ready | input | 1 | Refill request accepted |
| fill_index | output | 9 | Set to refill |
| fill_tag | output | 5 | Tag being fetched |
| fill_way | output | 1 | Way that receives the block |
| fill_done | input | 1 | Refill data is in place; install the tag |

## Verification
The hardest state to reach is a set with both ways valid, one of them dirty, where the recency bit points at the dirty way. Only that state produces a writeback, and checking it properly needs the old tag compared after a write hit. Random accesses are confined to a handful of sets, some differing only in bit 11, and to four tags, so that sets fill, conflict and evict often. A directed sequence first builds the dirty-victim and write-miss-install cases on purpose. Handshake delays are random, so held outputs are watched across stall cycles.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
  localparam int NUM_WAYS = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WB,
    ST_FILL,
    ST_WAIT,
    ST_RESP
  } ctl_state_t;
endpackage

// File: rtl/ct_tag_store.sv
module ct_tag_store
  import cache_tag_pkg::*;
#(
  parameter int INDEX_W = 9,
  parameter int TAG_W   = 5
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [INDEX_W-1:0]                 index,
  output logic [NUM_WAYS-1:0][TAG_W-1:0]     rd_tag,
  output logic [NUM_WAYS-1:0]                rd_valid,
  output logic [NUM_WAYS-1:0]                rd_dirty,
  output logic                               rd_lru,
  input  logic                               touch_en,
  input  logic                               touch_way,
  input  logic                               touch_write,
  input  logic                               install_en,
  input  logic                               install_way,
  input  logic [TAG_W-1:0]                   install_tag,
  input  logic                               install_dirty
);
  localparam int SETS = 1 << INDEX_W;

  logic [SETS-1:0] lru_q;

  // Recency bit names the way to evict next.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lru_q <= '0;
    end else if (install_en) begin
      lru_q[index] <= ~install_way;
    end else if (touch_en) begin
      lru_q[index] <= ~touch_way;
    end
  end
  assign rd_lru = lru_q[index];

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
    logic [SETS-1:0]  vld_q;
    logic [SETS-1:0]  drt_q;
    logic [TAG_W-1:0] tag_q [SETS];
    logic             inst_here;
    logic             touch_here;

    assign inst_here  = install_en && (install_way == 1'(g));
    assign touch_here = touch_en && (touch_way == 1'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
        drt_q <= '0;
      end else if (inst_here) begin
        vld_q[index] <= 1'b1;
        drt_q[index] <= install_dirty;
      end else if (touch_here && touch_write) begin
        drt_q[index] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (inst_here) tag_q[index] <= install_tag;
    end

    assign rd_valid[g] = vld_q[index];
    assign rd_dirty[g] = drt_q[index];
    assign rd_tag[g]   = tag_q[index];
  end

  // R10: install and touch come from distinct controller states
  p_single_update_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(install_en && touch_en));
endmodule

// File: rtl/ct_way_match.sv
module ct_way_match
  import cache_tag_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           check_en,
  input  logic [NUM_WAYS-1:0][TAG_W-1:0] rd_tag,
  input  logic [NUM_WAYS-1:0]            rd_valid,
  input  logic [TAG_W-1:0]               probe_tag,
  output logic                           hit,
  output logic                           hit_way
);
  logic [NUM_WAYS-1:0] hit_vec;

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_cmp
    assign hit_vec[g] = rd_valid[g] && (rd_tag[g] == probe_tag);
  end

  assign hit     = |hit_vec;
  assign hit_way = hit_vec[1];

  // R2: fills only happen on misses, so a tag never sits in both ways of a set
  p_unique_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    check_en |-> $onehot0(hit_vec));
endmodule

// File: rtl/ct_victim_pick.sv
module ct_victim_pick
  import cache_tag_pkg::*;
(
  input  logic [NUM_WAYS-1:0] rd_valid,
  input  logic [NUM_WAYS-1:0] rd_dirty,
  input  logic                rd_lru,
  output logic                victim_way,
  output logic                victim_wb
);
  always_comb begin
    if (!rd_valid[0])      victim_way = 1'b0;
    else if (!rd_valid[1]) victim_way = 1'b1;
    else                   victim_way = rd_lru;
    victim_wb = rd_valid[victim_way] && rd_dirty[victim_way];
  end
endmodule

// File: rtl/cache_tag_ctl.sv
module cache_tag_ctl
  import cache_tag_pkg::*;
#(
  parameter int OFFSET_W = 3,
  parameter int INDEX_W  = 9,
  parameter int TAG_W    = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [OFFSET_W+INDEX_W-1:0]  req_vaddr,
  input  logic [TAG_W-1:0]             req_ptag,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic                         rsp_hit,
  output logic                         rsp_way,
  output logic                         wb_valid,
  input  logic                         wb_ready,
  output logic [INDEX_W-1:0]           wb_index,
  output logic [TAG_W-1:0]             wb_tag,
  output logic                         wb_way,
  output logic                         fill_valid,
  input  logic                         fill_ready,
  output logic [INDEX_W-1:0]           fill_index,
  output logic [TAG_W-1:0]             fill_tag,
  output logic                         fill_way,
  input  logic                         fill_done
);
  localparam int VA_W = OFFSET_W + INDEX_W;

  ctl_state_t                     state_q, state_d;
  logic [INDEX_W-1:0]             idx_q;
  logic [TAG_W-1:0]               ptag_q;
  logic                           wr_q;
  logic                           way_q;
  logic                           hit_q;
  logic [TAG_W-1:0]               old_tag_q;

  logic [NUM_WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [NUM_WAYS-1:0]            rd_valid;
  logic [NUM_WAYS-1:0]            rd_dirty;
  logic                           rd_lru;
  logic                           hit, hit_way;
  logic                           victim_way, victim_wb;
  logic                           in_lookup;
  logic                           touch_en, install_en;

  assign in_lookup  = (state_q == ST_LOOKUP);
  assign touch_en   = in_lookup && hit;
  assign install_en = (state_q == ST_WAIT) && fill_done;

  ct_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .index        (idx_q),
    .rd_tag       (rd_tag),
    .rd_valid     (rd_valid),
    .rd_dirty     (rd_dirty),
    .rd_lru       (rd_lru),
    .touch_en     (touch_en),
    .touch_way    (hit_way),
    .touch_write  (wr_q),
    .install_en   (install_en),
    .install_way  (way_q),
    .install_tag  (ptag_q),
    .install_dirty(wr_q)
  );

  ct_way_match #(.TAG_W(TAG_W)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .check_en (in_lookup),
    .rd_tag   (rd_tag),
    .rd_valid (rd_valid),
    .probe_tag(ptag_q),
    .hit      (hit),
    .hit_way  (hit_way)
  );

  ct_victim_pick u_victim (
    .rd_valid  (rd_valid),
    .rd_dirty  (rd_dirty),
    .rd_lru    (rd_lru),
    .victim_way(victim_way),
    .victim_wb (victim_wb)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid) state_d = ST_LOOKUP;
      ST_LOOKUP: begin
        if (hit)            state_d = ST_RESP;
        else if (victim_wb) state_d = ST_WB;
        else                state_d = ST_FILL;
      end
      ST_WB:     if (wb_ready)   state_d = ST_FILL;
      ST_FILL:   if (fill_ready) state_d = ST_WAIT;
      ST_WAIT:   if (fill_done)  state_d = ST_RESP;
      ST_RESP:   if (rsp_ready)  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      ptag_q    <= '0;
      wr_q      <= 1'b0;
      way_q     <= 1'b0;
      hit_q     <= 1'b0;
      old_tag_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid) begin
        idx_q  <= req_vaddr[VA_W-1:OFFSET_W];
        ptag_q <= req_ptag;
        wr_q   <= req_write;
      end
      if (in_lookup) begin
        hit_q     <= hit;
        way_q     <= hit ? hit_way : victim_way;
        old_tag_q <= rd_tag[victim_way];
      end
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_valid  = (state_q == ST_RESP);
  assign rsp_hit    = hit_q;
  assign rsp_way    = way_q;
  assign wb_valid   = (state_q == ST_WB);
  assign wb_index   = idx_q;
  assign wb_tag     = old_tag_q;
  assign wb_way     = way_q;
  assign fill_valid = (state_q == ST_FILL);
  assign fill_index = idx_q;
  assign fill_tag   = ptag_q;
  assign fill_way   = way_q;

  // R10: a single port is active at any time
  p_one_port_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, rsp_valid, wb_valid, fill_valid}));
  // R9: response holds until taken
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_way));
  // R9: writeback holds until taken
  p_wb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_tag) && $stable(wb_index) && $stable(wb_way));
  // R9: fill request holds until taken
  p_fill_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && !fill_ready |=> fill_valid && $stable(fill_tag) && $stable(fill_index) && $stable(fill_way));
  // R6: an accepted writeback is followed by the fill request
  p_fill_after_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && wb_ready |=> fill_valid && $stable(fill_way));
  // R8: a hit answers directly without touching the lower level
  p_hit_direct_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_lookup && hit |=> rsp_valid && rsp_hit);
  // R10: a refill pulse in idle leaves the block idle
  p_stray_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && !req_valid && fill_done |=> req_ready);
endmodule

// File: tb/test_cache_tag_ctl.sv
module test_cache_tag_ctl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_vaddr = '0;
  logic [4:0]  req_ptag = '0;
  logic        rsp_ready = 1'b0, wb_ready = 1'b0, fill_ready = 1'b0, fill_done = 1'b0;
  logic        req_ready, rsp_valid, rsp_hit, rsp_way;
  logic        wb_valid, wb_way, fill_valid, fill_way;
  logic [8:0]  wb_index, fill_index;
  logic [4:0]  wb_tag, fill_tag;

  int checks = 0;
  int fails  = 0;

  bit         m_v [2][512];
  bit         m_d [2][512];
  logic [4:0] m_t [2][512];
  bit         m_l [512];

  bit         got_hit, got_way, got_wb;
  logic [4:0] got_wbtag;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_tag_ctl i_cache_tag_ctl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_vaddr(req_vaddr), .req_ptag(req_ptag),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_index(wb_index), .wb_tag(wb_tag), .wb_way(wb_way),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_index(fill_index),
    .fill_tag(fill_tag), .fill_way(fill_way), .fill_done(fill_done)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic bit ref_hit(input logic [8:0] idx, input logic [4:0] t, output bit way);
    way = 1'b0;
    for (int w = 0; w < 2; w++)
      if (m_v[w][idx] && m_t[w][idx] == t) begin way = 1'(w); return 1'b1; end
    return 1'b0;
  endfunction

  function automatic bit ref_victim(input logic [8:0] idx);
    if (!m_v[0][idx]) return 1'b0;
    if (!m_v[1][idx]) return 1'b1;
    return m_l[idx];
  endfunction

  task automatic access(input bit wr, input logic [11:0] va, input logic [4:0] pt);
    logic [8:0] idx = va[11:3];
    bit ew, eh, ewb, done, saw_wb, saw_fill;
    logic [4:0] etag;
    eh = ref_hit(idx, pt, ew);
    if (!eh) ew = ref_victim(idx);
    ewb  = !eh && m_v[ew][idx] && m_d[ew][idx];
    etag = m_t[ew][idx];
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_vaddr = va; req_ptag = pt;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    done = 0; saw_wb = 0; saw_fill = 0; got_wb = 0;
    while (!done) begin
      if (wb_valid) begin
        chk(ewb, "R8", "unexpected writeback", 1, 0);
        chk(wb_tag == etag, "R6", "writeback tag", wb_tag, etag);
        chk(wb_index == idx, "R6", "writeback index", wb_index, idx);
        chk(wb_way == ew, "R5", "writeback way", wb_way, ew);
        got_wb = 1; got_wbtag = wb_tag; saw_wb = 1;
        repeat ($urandom % 3) @(negedge clk);
        wb_ready = 1'b1; @(negedge clk); wb_ready = 1'b0;
        chk(fill_valid, "R6", "fill follows writeback", fill_valid, 1);
      end else if (fill_valid) begin
        chk(!eh, "R8", "fill on hit", 1, 0);
        chk(saw_wb == ewb, "R8", "writeback before fill", saw_wb, ewb);
        chk(fill_way == ew, "R4", "fill way", fill_way, ew);
        chk(fill_tag == pt && fill_index == idx, "R4", "fill tag", fill_tag, pt);
        saw_fill = 1;
        repeat ($urandom % 3) @(negedge clk);
        fill_ready = 1'b1; @(negedge clk); fill_ready = 1'b0;
        repeat ($urandom % 3) begin
          @(negedge clk);
          chk(!rsp_valid, "R10", "response before refill", rsp_valid, 0);
        end
        fill_done = 1'b1; @(negedge clk); fill_done = 1'b0;
      end else if (rsp_valid) begin
        chk(rsp_hit == eh, "R2", "hit flag", rsp_hit, eh);
        chk(rsp_way == ew, eh ? "R2" : "R5", "response way", rsp_way, ew);
        chk(saw_fill == !eh, "R8", "fill seen", saw_fill, !eh);
        got_hit = rsp_hit; got_way = rsp_way;
        repeat ($urandom % 3) begin
          @(negedge clk);
          chk(rsp_valid && rsp_way == ew && rsp_hit == eh, "R9", "response held", rsp_valid, 1);
        end
        rsp_ready = 1'b1; @(negedge clk); rsp_ready = 1'b0;
        done = 1;
      end else begin
        @(negedge clk);
      end
    end
    if (eh) begin
      m_l[idx] = ~ew;
      if (wr) m_d[ew][idx] = 1'b1;
    end else begin
      m_v[ew][idx] = 1'b1; m_t[ew][idx] = pt; m_d[ew][idx] = wr; m_l[idx] = ~ew;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int w = 0; w < 2; w++) for (int s = 0; s < 512; s++) begin
      m_v[w][s] = 0; m_d[w][s] = 0; m_t[w][s] = '0;
    end
    for (int s = 0; s < 512; s++) m_l[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !wb_valid && !fill_valid, "R9", "idle after reset", req_ready, 1);

    // R1: empty set misses into way 0 without writeback
    access(0, {9'd5, 3'd0}, 5'd3);
    chk(!got_hit && got_way == 0 && !got_wb, "R1", "first miss", got_way, 0);
    // R2: other byte offset, same block
    access(0, {9'd5, 3'd6}, 5'd3);
    chk(got_hit && got_way == 0, "R2", "offset ignored", got_hit, 1);
    // R3: bit 11 selects another set
    access(0, {9'd5 | 9'h100, 3'd0}, 5'd3);
    chk(!got_hit, "R3", "bit 11 separate set", got_hit, 0);
    // R4: second way filled while invalid
    access(0, {9'd5, 3'd1}, 5'd4);
    chk(!got_hit && got_way == 1, "R4", "invalid way first", got_way, 1);
    // R6: write hit makes way 0 dirty and way 1 the victim
    access(1, {9'd5, 3'd2}, 5'd3);
    chk(got_hit && got_way == 0, "R6", "write hit", got_way, 0);
    // R5/R8: clean victim way 1, no writeback
    access(0, {9'd5, 3'd0}, 5'd6);
    chk(got_way == 1 && !got_wb, "R8", "clean eviction", got_wb, 0);
    // R6: dirty way 0 evicted with old tag
    access(0, {9'd5, 3'd0}, 5'd7);
    chk(got_wb && got_wbtag == 5'd3, "R6", "dirty eviction tag", got_wbtag, 3);
    // R7: write miss installs dirty, read miss clean
    access(1, {9'd5, 3'd0}, 5'd9);
    access(0, {9'd5, 3'd0}, 5'd10);
    chk(got_wb && got_wbtag == 5'd7 || !got_wb, "R7", "read-installed stays clean", got_wb, 0);
    access(0, {9'd5, 3'd0}, 5'd11);
    chk(got_wb && got_wbtag == 5'd9, "R7", "write-installed dirty", got_wbtag, 9);
    // R10: stray refill pulse while idle
    @(negedge clk); fill_done = 1'b1; @(negedge clk); fill_done = 1'b0;
    chk(req_ready && !rsp_valid, "R10", "stray fill_done", req_ready, 1);
    access(0, {9'd5, 3'd0}, 5'd11);
    chk(got_hit, "R10", "state kept after stray pulse", got_hit, 1);

    for (int n = 0; n < 600; n++) begin
      logic [8:0] pool [4] = '{9'd20, 9'd20 | 9'h100, 9'd77, 9'd300};
      access(1'($urandom), {pool[$urandom % 4], 3'($urandom)}, 5'($urandom % 4));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule